// File: doc/BRIEF.md
# Fractional-N Pulse-Swallow Feedback Divider

This block is the feedback divider of a fractional-N frequency synthesizer. It runs on the output clock of a dual-modulus prescaler that divides by 16 or 17, and it drives that prescaler's modulus-select line. Each comparison period lasts a programmed number of prescaler cycles. For the first part of the period the prescaler is told to divide by 17, and for the rest it divides by 16. The VCO count per period is therefore 16 × program + effective swallow.

A modulo-13 accumulator advances by the fractional numerator once per period. Whenever it wraps, that period's swallow count is raised by one. The average division ratio is then 16 × program + swallow + numerator/13. One single-cycle comparison pulse marks the end of every period.

New swallow, program and numerator values are sampled only at period boundaries. A control FSM has three states:
- ST_BOOT is the single idle state after reset.
- ST_SWALLOW is the divide-by-17 stretch.
- ST_MAIN is the divide-by-16 stretch.

The FSM has these transitions:
- ST_BOOT moves to ST_SWALLOW, or to ST_MAIN when the effective swallow count is zero, on the first edge after reset.
- ST_SWALLOW moves to ST_MAIN when the last swallow cycle ends.
- ST_MAIN reloads into ST_SWALLOW or ST_MAIN at its terminal cycle.

Top module: `fracn_pulse_swallow_div`

## Requirements
- R1: Each period lasts exactly Pc prescaler cycles. Pc is the program input when that input is 18 or more, and 18 otherwise. The resulting VCO count is 16 × Pc + Se.
- R2: The modulus-select output is 1, meaning divide by 17, on the first Se cycles of a period and 0 on the remaining cycles. Se is the effective swallow count, which can be 0 to 16.
- R3: Once modulus-select has gone to 0 within a period, it stays 0 until the period's last cycle has ended.
- R4: At each period start the accumulator adds the numerator. If the sum is 13 or more, 13 is subtracted and Se equals swallow + 1. Otherwise Se equals swallow. The accumulator is 0 after reset.
- R5: A numerator of 13, 14 or 15 behaves exactly like 12.
- R6: Over any 13 consecutive periods with a constant numerator N, the sum of (Se − swallow) equals min(N, 12).
- R7: The comparison pulse is high for exactly one cycle per period, and that cycle is the last cycle of the period.
- R8: The inputs are sampled only on the clock edge that ends a pulse cycle, or on the first edge after reset. Input changes at any other time do not alter the period in progress.
- R9: While reset is asserted, modulus-select and the comparison pulse are 0. The first period begins on the cycle after the first clock edge following the release of reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_presc | input | 1 | Prescaler output clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| swallow_i | input | 4 | Swallow count, 0 to 15 |
| program_i | input | 10 | Program count; values below 18 are raised to 18 |
| numer_i | input | 4 | Fractional numerator over 13; values above 12 are treated as 12 |
| modsel17_o | output | 1 | 1 = prescaler divides by 17, 0 = divides by 16 |
| cmp_pulse_o | output | 1 | One-cycle pulse on the last cycle of each period |

## Verification
Inputs are sampled at the edge that ends a pulse cycle, so the first cycle governed by new values is the very next cycle. Every result is therefore due within the period that follows the pulse. The bench drives inputs at the falling edge of the pulse cycle and samples outputs at each falling edge. For each period it counts cycles and divide-by-17 cycles until the pulse appears, and compares both counts against an arithmetic model of the accumulator and the program-count clamp. Input changes in the middle of a period are checked against the counts of that same period, and the effect of reset is checked on the first period after release.

// File: rtl/fnd_pkg.sv
package fnd_pkg;

    typedef enum logic [1:0] {
        ST_BOOT    = 2'd0,
        ST_SWALLOW = 2'd1,
        ST_MAIN    = 2'd2
    } fnd_state_e;

endpackage

// File: rtl/fnd_frac_acc.sv
module fnd_frac_acc #(
    parameter int NUM_W = 4,
    parameter int DEN   = 13,
    parameter int ACC_W = $clog2(DEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic [NUM_W-1:0] numer_i,
    output logic             carry_o
);
    localparam int NUM_MAX = DEN - 1;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_d;
    int               num_i;
    int               sum_i;

    // saturate numerator, add, and fold back modulo DEN
    always_comb begin
        num_i = int'(numer_i);
        if (num_i > NUM_MAX) begin
            num_i = NUM_MAX;
        end
        sum_i   = int'(acc_q) + num_i;
        carry_o = (sum_i >= DEN);
        if (carry_o) begin
            acc_d = ACC_W'(sum_i - DEN);
        end else begin
            acc_d = ACC_W'(sum_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (step_i) begin
            acc_q <= acc_d;
        end
    end

    AST_ACC_BELOW_DEN: assert property (@(posedge clk) disable iff (!rst_n)
        int'(acc_q) < DEN); // R4

    AST_WRAP_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && carry_o) |=> (acc_q < $past(acc_q))); // R5

endmodule

// File: rtl/fnd_prog_clamp.sv
module fnd_prog_clamp #(
    parameter int PG_W   = 10,
    parameter int SE_W   = 5,
    parameter int PG_MIN = 18
) (
    input  logic [PG_W-1:0] prog_i,
    input  logic [SE_W-1:0] seff_i,
    output logic [PG_W-1:0] prog_o
);
    localparam int SE_MAX = (1 << SE_W) - 1;

    generate
        if (PG_MIN > SE_MAX) begin : g_fixed_floor
            // every legal swallow is below the floor: a plain minimum suffices
            always_comb begin
                prog_o = (int'(prog_i) < PG_MIN) ? PG_W'(PG_MIN) : prog_i;
            end
        end else begin : g_swallow_floor
            int floor_i;
            always_comb begin
                floor_i = int'(seff_i) + 1;
                if (floor_i < PG_MIN) begin
                    floor_i = PG_MIN;
                end
                prog_o = (int'(prog_i) < floor_i) ? PG_W'(floor_i) : prog_i;
            end
        end
    endgenerate

endmodule

// File: rtl/fnd_count_fsm.sv
module fnd_count_fsm
    import fnd_pkg::*;
#(
    parameter int PG_W = 10,
    parameter int SE_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PG_W-1:0] ld_prog_i,
    input  logic [SE_W-1:0] ld_swal_i,
    output logic            load_o,
    output logic            mod_sel_o,
    output logic            pulse_o
);
    fnd_state_e      state_q, state_d;
    logic [PG_W-1:0] cnt_q, cnt_d;
    logic [SE_W-1:0] swl_q, swl_d;

    // outputs
    always_comb begin
        mod_sel_o = (state_q == ST_SWALLOW);
        pulse_o   = (state_q == ST_MAIN) && (cnt_q == PG_W'(1));
        load_o    = (state_q == ST_BOOT) || pulse_o;
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        swl_d   = swl_q;
        if (load_o) begin
            cnt_d   = ld_prog_i;
            swl_d   = ld_swal_i;
            state_d = (ld_swal_i != '0) ? ST_SWALLOW : ST_MAIN;
        end else begin
            unique case (state_q)
                ST_SWALLOW: begin
                    cnt_d = cnt_q - 1'b1;
                    swl_d = swl_q - 1'b1;
                    if (swl_q == SE_W'(1)) begin
                        state_d = ST_MAIN;
                    end
                end
                ST_MAIN: begin
                    cnt_d = cnt_q - 1'b1;
                end
                default: begin
                    state_d = ST_BOOT;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_BOOT;
            cnt_q   <= '0;
            swl_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            swl_q   <= swl_d;
        end
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o); // R7

    AST_NO_REENTER_SWALLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MAIN && !pulse_o) |=> !mod_sel_o); // R3

    AST_LOAD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |-> (ld_prog_i > {{(PG_W-SE_W){1'b0}}, ld_swal_i})); // R1

    AST_CNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_BOOT) |-> (cnt_q != '0)); // R1

endmodule

// File: rtl/fracn_pulse_swallow_div.sv
module fracn_pulse_swallow_div #(
    parameter int SW_W   = 4,
    parameter int PG_W   = 10,
    parameter int NUM_W  = 4,
    parameter int DEN    = 13,
    parameter int PG_MIN = 18
) (
    input  logic             clk_presc,
    input  logic             rst_n,
    input  logic [SW_W-1:0]  swallow_i,
    input  logic [PG_W-1:0]  program_i,
    input  logic [NUM_W-1:0] numer_i,
    output logic             modsel17_o,
    output logic             cmp_pulse_o
);
    localparam int SE_W = SW_W + 1;

    logic            load_w;
    logic            carry_w;
    logic [SE_W-1:0] seff_w;
    logic [PG_W-1:0] prog_w;

    assign seff_w = {1'b0, swallow_i} + {{(SE_W-1){1'b0}}, carry_w};

    fnd_frac_acc #(
        .NUM_W (NUM_W),
        .DEN   (DEN)
    ) u_acc (
        .clk     (clk_presc),
        .rst_n   (rst_n),
        .step_i  (load_w),
        .numer_i (numer_i),
        .carry_o (carry_w)
    );

    fnd_prog_clamp #(
        .PG_W   (PG_W),
        .SE_W   (SE_W),
        .PG_MIN (PG_MIN)
    ) u_clamp (
        .prog_i (program_i),
        .seff_i (seff_w),
        .prog_o (prog_w)
    );

    fnd_count_fsm #(
        .PG_W (PG_W),
        .SE_W (SE_W)
    ) u_fsm (
        .clk       (clk_presc),
        .rst_n     (rst_n),
        .ld_prog_i (prog_w),
        .ld_swal_i (seff_w),
        .load_o    (load_w),
        .mod_sel_o (modsel17_o),
        .pulse_o   (cmp_pulse_o)
    );

    AST_SEFF_BOUND: assert property (@(posedge clk_presc) disable iff (!rst_n)
        load_w |-> (seff_w <= {1'b0, swallow_i} + SE_W'(1))); // R4

endmodule

// File: tb/fracn_pulse_swallow_div_tb_top.sv
module fracn_pulse_swallow_div_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] sw = '0;
    logic [9:0] pg = 10'd18;
    logic [3:0] nm = '0;
    logic       modsel;
    logic       pulse;

    int n_vec = 0;
    int n_bad = 0;
    int acc_m = 0;
    int cyc   = 0;

    always #5 clk = ~clk;

    fracn_pulse_swallow_div dut_i (
        .clk_presc   (clk),
        .rst_n       (rst_n),
        .swallow_i   (sw),
        .program_i   (pg),
        .numer_i     (nm),
        .modsel17_o  (modsel),
        .cmp_pulse_o (pulse)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 190000);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // model: returns expected cycles and swallow cycles, advances accumulator
    task automatic predict(input int s, input int p, input int n, output int en, output int eh);
        int ns;
        ns = (n > 12) ? 12 : n;
        acc_m = acc_m + ns;
        eh = s;
        if (acc_m >= 13) begin
            acc_m = acc_m - 13;
            eh = s + 1;
        end
        en = (p < 18) ? 18 : p;
    endtask

    task automatic measure(input bit glitch, output int n, output int h, output bit contig);
        bit seen0;
        n = 0;
        h = 0;
        contig = 1'b1;
        seen0 = 1'b0;
        forever begin
            @(negedge clk);
            n++;
            if (modsel) begin
                h++;
                if (seen0) contig = 1'b0;
            end else begin
                seen0 = 1'b1;
            end
            if (glitch && n == 3) begin
                sw = ~sw;
                pg = pg ^ 10'h2A5;
                nm = ~nm;
            end
            if (pulse || n > 1100) break;
        end
    endtask

    // drive the values for the next period, measure it, compare
    task automatic run_period(input int s, input int p, input int n, input bit glitch, output int extra);
        int en, eh, an, ah;
        bit ct;
        string rq;
        sw = 4'(s);
        pg = 10'(p);
        nm = 4'(n);
        predict(s, p, n, en, eh);
        measure(glitch, an, ah, ct);
        rq = glitch ? "R8" : ((p < 18) ? "R1 clamp" : "R1");
        chk(an == en, rq, an, en);
        rq = glitch ? "R8" : ((n > 12) ? "R5" : "R4");
        chk(ah == eh, rq, ah, eh);
        chk(ct, "R2 R3 contiguous", int'(ct), 1);
        extra = ah - s;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(modsel == 1'b0, "R9 modsel in reset", int'(modsel), 0);
            chk(pulse == 1'b0, "R9 pulse in reset", int'(pulse), 0);
        end
        acc_m = 0;
    endtask

    initial begin
        int ex, tot;
        do_reset();
        // sweep every numerator, 13 periods each, varied swallow and program
        for (int n = 0; n < 16; n++) begin
            tot = 0;
            for (int k = 0; k < 13; k++) begin
                if (n == 0 && k == 0) begin
                    sw = 4'd0; pg = 10'd18; nm = 4'd0;
                    rst_n = 1'b1;
                end
                run_period((k + n) % 16, 18 + ((k * 7 + n) % 23), n, 1'b0, ex);
                tot += ex;
            end
            chk(tot == ((n > 12) ? 12 : n), "R6 average", tot, (n > 12) ? 12 : n);
        end
        // boundary programs and swallows
        run_period(15, 1023, 12, 1'b0, ex);
        run_period(15, 1023, 12, 1'b0, ex);
        run_period(0, 0, 0, 1'b0, ex);
        run_period(15, 1, 7, 1'b0, ex);
        run_period(3, 17, 15, 1'b0, ex);
        run_period(15, 18, 12, 1'b0, ex);
        // mid-period input changes must not touch the current period
        for (int k = 0; k < 6; k++) begin
            run_period(k * 3, 20 + k * 9, 4 + k, 1'b1, ex);
        end
        // reset in mid-run clears the accumulator
        do_reset();
        sw = 4'd2; pg = 10'd30; nm = 4'd12;
        @(negedge clk);
        rst_n = 1'b1;
        run_period(2, 30, 12, 1'b0, ex);
        chk(ex == 0, "R9 acc cleared first", ex, 0);
        run_period(2, 30, 12, 1'b0, ex);
        chk(ex == 1, "R9 acc cleared second", ex, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule